// File: doc/BRIEF.md
# Bus Controller Error-Capture and Cycle-Trigger Register Block

This block is the small register slice of a bus master/target controller that software uses for three jobs. It records where a failed bus transaction happened. It lets software start interrupt-acknowledge and special bus cycles. It holds the setup for posted reads. Software reaches it through a plain 32-bit register port: a word index, a write strobe, a read strobe, and read data that is registered.

The error side takes in single-cycle error events that carry an address and a type, which is either general or parity. The first such event after the status flags are clear fixes the recorded address. Later events only add their flag until software clears the flags by writing ones.

Accessing the trigger word does not change any stored state. It only produces a one-cycle launch request for the bus-cycle engine. The posted-read word drives several outputs continuously: the burst word count, the active-low lane enables, the upper four bits of a 36-bit system address, and the mask gating of the done and abort interrupts.

Top module: `busctl_csr`

## Requirements
- R1: After reset the following hold. The configuration word (index 3) reads 0x0000_0024. The error address (index 0) reads 0. The status word (index 1) reads 0. `err_flags` is 0, `burst_words` is 3, `ext_addr[35:32]` is 4, `lane_en_n` is 0, and no trigger pulse is active.
- R2: An `err_valid` event that arrives while both status flags are clear stores `err_addr`. The stored address is read at index 0. The event also sets a status flag: bit 0 for a general error (`err_parity`=0) or bit 1 for a parity error (`err_parity`=1). Both the status word at index 1 and `err_flags` show this flag.
- R3: While any status flag is set, later error events leave the stored address unchanged. Their flag bit is still ORed into the status.
- R4: Writing ones to bits 1:0 of index 1 clears those flags, and writing zeros leaves flags unchanged. A partial clear keeps the stored address locked. Once both flags are clear, the next error is stored as a new first error.
- R5: Suppose an error event arrives in the same cycle as a write that clears every flag still set. That error is stored as the new first error, and its flag remains set.
- R6: A read of index 2 raises `intack_req` for exactly one cycle, the cycle after the access. The read returns 0.
- R7: A write of index 2 raises `special_req` for exactly one cycle, the cycle after the access. The written data changes no register.
- R8: The configuration word at index 3 has these fields: lane mask in bits 15:12, abort mask in bit 9, done mask in bit 8, burst field in bits 6:4, and high address in bits 3:0. Reserved bits read as 0 and ignore writes.
- R9: `burst_words` equals the burst field plus one, which ranges from 1 to 8.
- R10: `ext_addr` is the high address field concatenated above `sbus_addr_lo`.
- R11: `lane_en_n[i]` equals lane-mask bit 12+i. A 1 masks (disables) the lane, and lane 3 covers data bits 31:24.
- R12: `irq_rd_done` follows `rd_done_evt` when bit 8 is 0 and stays low when bit 8 is 1. `irq_rd_abort` follows `rd_abort_evt` under bit 9 in the same way. Both are combinational, with no added cycle.
- R13: Index 0 is read-only, so writes to it leave the stored address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| err_valid | input | 1 | Failed-transaction event |
| err_parity | input | 1 | Event type: 1 parity, 0 general |
| err_addr | input | 32 | Address of the failed transaction |
| err_flags | output | 2 | Status flags; nonzero means the stored address is valid |
| intack_req | output | 1 | One-cycle interrupt-acknowledge cycle request |
| special_req | output | 1 | One-cycle special cycle request |
| sbus_addr_lo | input | 32 | Low system address bits from the read engine |
| ext_addr | output | 36 | Extended system address |
| burst_words | output | 4 | Posted-read burst length in words |
| lane_en_n | output | 4 | Active-low byte-lane enables |
| rd_done_evt | input | 1 | Raw posted-read done event |
| rd_abort_evt | input | 1 | Raw posted-read abort event |
| irq_rd_done | output | 1 | Masked done interrupt |
| irq_rd_abort | output | 1 | Masked abort interrupt |

## Verification
Each output has a fixed due time after its stimulus:

- Read data, trigger pulses and stored error state appear one clock edge after the strobe or event.
- The configuration outputs follow one edge after the write.
- The interrupt gating is due in the same cycle as its event.

The bench drives inputs on the falling edge. A read pushes its expected word into a queue, and a monitor pops that entry at the falling edge after the next rising edge. Pulse checks sample exactly one falling edge after the access and again one edge later, to catch a missing or stretched pulse. Combinational checks sample a short delay after the input changes.

// File: rtl/busctl_pkg.sv
// Package: shared widths, word indices and field positions for the
// bus controller register block. Assumes a 32-bit data word.
package busctl_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 2;
    localparam int HI_W     = 4;
    localparam int BS_W     = 3;
    localparam int LANES    = DATA_W / 8;
    localparam int FLAG_W   = 2;

    // Word indices
    localparam logic [IDX_W-1:0] IDX_ERRADDR = 2'd0;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_TRIG    = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CFG     = 2'd3;

    // Configuration field positions
    localparam int LANE_LSB = 12;
    localparam int AMSK_BIT = 9;
    localparam int DMSK_BIT = 8;
    localparam int BS_LSB   = 4;
    localparam int HI_LSB   = 0;

    // Reset values of configuration fields
    localparam logic [BS_W-1:0] BS_RST = 3'd2;
    localparam logic [HI_W-1:0] HI_RST = 4'd4;

    // Status flag bit positions
    localparam int FLG_GEN = 0;
    localparam int FLG_PAR = 1;
endpackage

// File: rtl/busctl_errcap.sv
// Module: busctl_errcap
// Stores the address of the first failed transaction and keeps the two
// status flags, which are cleared by writing ones to them.
// Assumes: at most one error event per cycle. An event in the same
// cycle as a clear that empties the flags is stored as a new first error.
module busctl_errcap
    import busctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_bits,
    input  logic              ev_valid,
    input  logic              ev_parity,
    input  logic [DATA_W-1:0] ev_addr,
    output logic [DATA_W-1:0] cap_addr,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_kept;
    logic [FLAG_W-1:0] ev_bits;
    logic [DATA_W-1:0] addr_q;
    logic              armed;

    // Flags that survive this cycle's clear, and the flag this event raises
    always_comb begin
        flags_kept = flags_q & ~(clr_we ? clr_bits : '0);
        ev_bits    = '0;
        ev_bits[ev_parity ? FLG_PAR : FLG_GEN] = ev_valid;
        armed      = (flags_kept == '0);
    end

    // Flag accumulation and first-error address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            addr_q  <= '0;
        end else begin
            flags_q <= flags_kept | ev_bits;
            if (ev_valid && armed) begin
                addr_q <= ev_addr;
            end
        end
    end

    assign cap_addr = addr_q;
    assign flags    = flags_q;
endmodule

// File: rtl/busctl_trigger.sv
// Module: busctl_trigger
// Turns an access to the trigger word into one-cycle launch requests:
// a read starts an interrupt-acknowledge cycle and a write starts a
// special cycle. Assumes the strobes last one cycle per access.
module busctl_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd,
    input  logic wr,
    output logic intack_pulse,
    output logic special_pulse
);
    logic intack_q;
    logic special_q;

    // Register each request so it lands one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intack_q  <= 1'b0;
            special_q <= 1'b0;
        end else begin
            intack_q  <= sel && rd;
            special_q <= sel && wr;
        end
    end

    assign intack_pulse  = intack_q;
    assign special_pulse = special_q;
endmodule

// File: rtl/busctl_prcfg.sv
// Module: busctl_prcfg
// Holds the posted-read configuration fields and derives the burst
// count, lane enables, extended address and masked interrupts.
// Assumes: reserved bits are neither stored nor read back.
module busctl_prcfg
    import busctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    sbus_lo,
    input  logic                 done_evt,
    input  logic                 abort_evt,
    output logic [DATA_W-1:0]    rd_word,
    output logic [HI_W+DATA_W-1:0] ext_addr,
    output logic [BS_W:0]        burst_words,
    output logic [LANES-1:0]     lane_en_n,
    output logic                 irq_done,
    output logic                 irq_abort
);
    logic [LANES-1:0] lane_q;
    logic             amsk_q;
    logic             dmsk_q;
    logic [BS_W-1:0]  bs_q;
    logic [HI_W-1:0]  hi_q;
    logic             unused_bits;

    // Field storage, written as a whole word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            amsk_q <= 1'b0;
            dmsk_q <= 1'b0;
            bs_q   <= BS_RST;
            hi_q   <= HI_RST;
        end else if (we) begin
            lane_q <= wdata[LANE_LSB +: LANES];
            amsk_q <= wdata[AMSK_BIT];
            dmsk_q <= wdata[DMSK_BIT];
            bs_q   <= wdata[BS_LSB +: BS_W];
            hi_q   <= wdata[HI_LSB +: HI_W];
        end
    end

    // Readback with reserved positions held at zero
    always_comb begin
        rd_word = '0;
        rd_word[LANE_LSB +: LANES] = lane_q;
        rd_word[AMSK_BIT]          = amsk_q;
        rd_word[DMSK_BIT]          = dmsk_q;
        rd_word[BS_LSB +: BS_W]    = bs_q;
        rd_word[HI_LSB +: HI_W]    = hi_q;
    end

    // Per-lane active-low enable: a set mask bit disables its lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_n[g] = lane_q[g];
    end

    assign burst_words = {1'b0, bs_q} + 1'b1;
    assign ext_addr    = {hi_q, sbus_lo};
    assign irq_done    = done_evt  & ~dmsk_q;
    assign irq_abort   = abort_evt & ~amsk_q;
    assign unused_bits = ^{wdata[DATA_W-1:LANE_LSB+LANES], wdata[LANE_LSB-1:AMSK_BIT+1],
                           wdata[BS_LSB+BS_W]};
endmodule

// File: rtl/busctl_csr.sv
// Module: busctl_csr (top)
// Register block for the bus controller: first-error address capture,
// cycle triggers and posted-read configuration behind a 32-bit word port.
// Assumes: read data is registered and valid the cycle after reg_rd;
// index 0 is read-only and the trigger word reads as zero.
module busctl_csr
    import busctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        err_valid,
    input  logic        err_parity,
    input  logic [31:0] err_addr,
    output logic [1:0]  err_flags,
    output logic        intack_req,
    output logic        special_req,
    input  logic [31:0] sbus_addr_lo,
    output logic [35:0] ext_addr,
    output logic [3:0]  burst_words,
    output logic [3:0]  lane_en_n,
    input  logic        rd_done_evt,
    input  logic        rd_abort_evt,
    output logic        irq_rd_done,
    output logic        irq_rd_abort
);
    logic [DATA_W-1:0] cap_addr;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              sel_stat;
    logic              sel_trig;
    logic              sel_cfg;

    // Word decode
    always_comb begin
        sel_stat = (reg_addr == IDX_STATUS);
        sel_trig = (reg_addr == IDX_TRIG);
        sel_cfg  = (reg_addr == IDX_CFG);
    end

    busctl_errcap u_errcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (reg_wr && sel_stat),
        .clr_bits  (reg_wdata[FLAG_W-1:0]),
        .ev_valid  (err_valid),
        .ev_parity (err_parity),
        .ev_addr   (err_addr),
        .cap_addr  (cap_addr),
        .flags     (err_flags)
    );

    busctl_trigger u_trig (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel_trig),
        .rd            (reg_rd),
        .wr            (reg_wr),
        .intack_pulse  (intack_req),
        .special_pulse (special_req)
    );

    busctl_prcfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_wr && sel_cfg),
        .wdata       (reg_wdata),
        .sbus_lo     (sbus_addr_lo),
        .done_evt    (rd_done_evt),
        .abort_evt   (rd_abort_evt),
        .rd_word     (cfg_word),
        .ext_addr    (ext_addr),
        .burst_words (burst_words),
        .lane_en_n   (lane_en_n),
        .irq_done    (irq_rd_done),
        .irq_abort   (irq_rd_abort)
    );

    // Read-data select
    always_comb begin
        unique case (reg_addr)
            IDX_ERRADDR: rd_mux = cap_addr;
            IDX_STATUS:  rd_mux = {{(DATA_W-FLAG_W){1'b0}}, err_flags};
            IDX_CFG:     rd_mux = cfg_word;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data, loaded on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/busctl_csr_chk.sv
// Module: busctl_csr_chk
// Property checker attached to busctl_csr. It only observes.
module busctl_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        err_valid,
    input logic [1:0]  err_flags,
    input logic [31:0] cap_addr,
    input logic        intack_req,
    input logic        special_req,
    input logic [3:0]  burst_words,
    input logic        rd_done_evt,
    input logic        rd_abort_evt,
    input logic        irq_rd_done,
    input logic        irq_rd_abort
);
    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (err_flags != 2'b00)); // R2

    AST_FIRST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags != 2'b00) && !(reg_wr && reg_addr == 2'd1 &&
          ((err_flags & ~reg_wdata[1:0]) == 2'b00))) |=> $stable(cap_addr)); // R3

    AST_INTACK_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> intack_req); // R6

    AST_INTACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intack_req) |-> $past(reg_rd && reg_addr == 2'd2)); // R6

    AST_SPECIAL_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> special_req); // R7

    AST_SPECIAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(special_req) |-> $past(reg_wr && reg_addr == 2'd2)); // R7

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_words >= 4'd1) && (burst_words <= 4'd8)); // R9

    AST_IRQ_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd_done |-> rd_done_evt); // R12

    AST_IRQ_ABORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd_abort |-> rd_abort_evt); // R12
endmodule

bind busctl_csr busctl_csr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .err_valid    (err_valid),
    .err_flags    (err_flags),
    .cap_addr     (cap_addr),
    .intack_req   (intack_req),
    .special_req  (special_req),
    .burst_words  (burst_words),
    .rd_done_evt  (rd_done_evt),
    .rd_abort_evt (rd_abort_evt),
    .irq_rd_done  (irq_rd_done),
    .irq_rd_abort (irq_rd_abort)
);

// File: tb/sim_busctl_csr.sv
`timescale 1ns/1ps
// Scoreboard bench for busctl_csr: read tasks queue expected words, a
// monitor compares them as read data emerges; direct checks cover pulses
// and continuous outputs.
module sim_busctl_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_valid = 1'b0;
    logic        err_parity = 1'b0;
    logic [31:0] err_addr = '0;
    logic [1:0]  err_flags;
    logic        intack_req;
    logic        special_req;
    logic [31:0] sbus_addr_lo = '0;
    logic [35:0] ext_addr;
    logic [3:0]  burst_words;
    logic [3:0]  lane_en_n;
    logic        rd_done_evt = 1'b0;
    logic        rd_abort_evt = 1'b0;
    logic        irq_rd_done;
    logic        irq_rd_abort;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    busctl_csr u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_valid(err_valid), .err_parity(err_parity), .err_addr(err_addr),
        .err_flags(err_flags), .intack_req(intack_req), .special_req(special_req),
        .sbus_addr_lo(sbus_addr_lo), .ext_addr(ext_addr), .burst_words(burst_words),
        .lane_en_n(lane_en_n), .rd_done_evt(rd_done_evt), .rd_abort_evt(rd_abort_evt),
        .irq_rd_done(irq_rd_done), .irq_rd_abort(irq_rd_abort)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: a read strobe seen at a rising edge has its data due at the next falling edge
    always @(posedge clk) rd_seen <= rst_n && reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), {32'd0, reg_rdata}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    // Driver tasks: start at a falling edge, end at the following falling edge
    task automatic rd_word(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = idx;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_word(input logic [1:0] idx, input logic [31:0] data);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic raise_err(input logic [31:0] a, input logic par);
        err_valid = 1'b1; err_addr = a; err_parity = par;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 burst_words", 64'(burst_words), 64'd3);
        check("R1 ext_addr hi", 64'(ext_addr[35:32]), 64'd4);
        check("R1 lane_en_n", 64'(lane_en_n), 64'd0);
        check("R1 err_flags", 64'(err_flags), 64'd0);
        check("R1 pulses idle", 64'({intack_req, special_req}), 64'd0);
        rd_word(2'd3, 32'h0000_0024, "R1 cfg reset");
        rd_word(2'd0, 32'h0, "R1 erraddr reset");
        rd_word(2'd1, 32'h0, "R1 status reset");

        // R8 field layout, R9 R10 R11 R12 derived outputs
        wr_word(2'd3, 32'hFFFF_FFFF);
        rd_word(2'd3, 32'h0000_F37F, "R8 reserved read zero");
        check("R9 burst max", 64'(burst_words), 64'd8);
        check("R11 all lanes masked", 64'(lane_en_n), 64'hF);
        rd_done_evt = 1'b1; rd_abort_evt = 1'b1; #1;
        check("R12 both masked", 64'({irq_rd_done, irq_rd_abort}), 64'd0);
        rd_done_evt = 1'b0; rd_abort_evt = 1'b0;
        @(negedge clk);
        wr_word(2'd3, 32'h0000_5105);
        rd_word(2'd3, 32'h0000_5105, "R8 field readback");
        check("R9 burst min", 64'(burst_words), 64'd1);
        check("R11 lane pattern", 64'(lane_en_n), 64'h5);
        sbus_addr_lo = 32'h89AB_CDEF; #1;
        check("R10 ext_addr", 64'(ext_addr), 64'h5_89AB_CDEF);
        rd_done_evt = 1'b1; rd_abort_evt = 1'b1; #1;
        check("R12 done masked abort open", 64'({irq_rd_done, irq_rd_abort}), 64'd1);
        rd_done_evt = 1'b0; rd_abort_evt = 1'b0;
        @(negedge clk);
        wr_word(2'd3, 32'h0000_0230);
        check("R9 burst four", 64'(burst_words), 64'd4);
        rd_done_evt = 1'b1; rd_abort_evt = 1'b1; #1;
        check("R12 abort masked done open", 64'({irq_rd_done, irq_rd_abort}), 64'd2);
        rd_done_evt = 1'b0; #1;
        check("R12 no event no irq", 64'(irq_rd_done), 64'd0);
        rd_abort_evt = 1'b0;
        @(negedge clk);

        // R7 special cycle trigger
        wr_word(2'd2, 32'hDEAD_BEEF);
        check("R7 special pulse high", 64'({special_req, intack_req}), 64'd2);
        @(negedge clk);
        check("R7 special pulse ends", 64'(special_req), 64'd0);
        rd_word(2'd3, 32'h0000_0230, "R7 cfg untouched");
        rd_word(2'd0, 32'h0, "R7 erraddr untouched");

        // R6 interrupt-acknowledge trigger
        rd_word(2'd2, 32'h0, "R6 trigger read data");
        check("R6 intack pulse high", 64'({intack_req, special_req}), 64'd2);
        @(negedge clk);
        check("R6 intack pulse ends", 64'(intack_req), 64'd0);

        // R13 read-only error address
        wr_word(2'd0, 32'h1234_5678);
        rd_word(2'd0, 32'h0, "R13 erraddr write ignored");

        // R2 first error
        raise_err(32'h1000_0040, 1'b0);
        check("R2 flags general", 64'(err_flags), 64'd1);
        rd_word(2'd0, 32'h1000_0040, "R2 captured addr");
        rd_word(2'd1, 32'h1, "R2 status word");

        // R3 later error keeps address, adds flag
        raise_err(32'h2000_0080, 1'b1);
        rd_word(2'd0, 32'h1000_0040, "R3 addr held");
        rd_word(2'd1, 32'h3, "R3 flags accumulate");

        // R4 partial clear keeps lock, full clear re-arms
        wr_word(2'd1, 32'h0000_0001);
        rd_word(2'd1, 32'h2, "R4 partial clear");
        raise_err(32'h3000_00C0, 1'b0);
        rd_word(2'd0, 32'h1000_0040, "R4 still locked");
        wr_word(2'd1, 32'h0000_0003);
        check("R4 flags cleared", 64'(err_flags), 64'd0);
        raise_err(32'h4000_0100, 1'b0);
        rd_word(2'd0, 32'h4000_0100, "R4 re-armed capture");

        // R5 error in the same cycle as the clearing write
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
        err_valid = 1'b1; err_addr = 32'h5000_0200; err_parity = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; err_valid = 1'b0;
        check("R5 new flag kept", 64'(err_flags), 64'd2);
        rd_word(2'd0, 32'h5000_0200, "R5 same-cycle capture");

        @(negedge clk);
        @(negedge clk);
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule